// File: doc/BRIEF.md
# ADC Conversion Timing Sequencer

This block sequences one 8-bit successive-approximation conversion at a time. A conversion is started either by host strobes (software start) or by a dedicated start pin (hardware start). The sequencer then opens a sampling window, steps a SAR register against a comparator bit while driving the trial code to an external DAC, latches the result and signals completion. Completion is signalled on one active-low line that works either as a one-clock interrupt pulse or as a busy-low level.

In software start the sampling window is a fixed number of clocks. In hardware start the window is as long as the start pin is held low, so the host can stretch acquisition for high-impedance sources. The sequencer drops into a light power-down when the host does not read within one clock of a finished conversion. It drops into a deeper power-down while chip select is high. Each result carries a flag that marks the first conversion after reset or after a deep power-down as suspect. A gate output tells an external clock gate when the local oscillator must run.

Top module: `adcseq_top`

## Requirements
- R1: After reset `irq_n` is 1, `sampling`, `auto_pd`, `soft_pd` and `result_invalid` are 0, `result` is 0, and `clk_en` is 1 with `int_clk_sel`=0 and 0 with `int_clk_sel`=1.
- R2: With `sw_mode`=1 and `cs_n`=0, a rising edge of `wr_n` or of `rd_n` seen at a clock edge starts sampling. `sampling` is then high for exactly 6 clocks, followed at once by 10 conversion clocks.
- R3: With `sw_mode`=0 and `cs_n`=0, a falling edge of `start_n` starts sampling. `sampling` stays high for as many clocks as `start_n` is seen low, and the 10-clock conversion begins at the clock edge that sees `start_n` high again.
- R4: During conversion, `dac_code` tests bits 7 down to 0, one per clock. Each trial bit is kept when `cmp`=1, meaning the input is at or above `dac_code`. The final code is loaded into `result` and holds until the next conversion latches.
- R5: With `eoc_mode`=0, `irq_n` goes low for exactly one clock, the clock after the conversion ends. `result` is already valid during that clock.
- R6: With `eoc_mode`=1, `irq_n` is low for exactly the 10 conversion clocks and high at all other times.
- R7: If `rd_n` is not low in the clock after conversion ends, `auto_pd` rises one clock later and stays high until the next trigger. If `rd_n` is low in that clock, `auto_pd` stays 0.
- R8: `cs_n` held high for H clocks puts the block in software power-down. `soft_pd` is high for max(H,2)+2 clocks in total: at least 2 clocks down, then 2 resume clocks. Triggers are not accepted in that time.
- R9: `result_invalid` is 1 with the first result after reset or after a software power-down, and 0 with every other result.
- R10: With `int_clk_sel`=1, `clk_en` is high exactly while sampling, converting and in the clock after conversion, and low otherwise. With `int_clk_sel`=0, `clk_en` is always 1.
- R11: A trigger edge that arrives while sampling or converting is ignored and does not change the sampling length or the conversion timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cs_n | input | 1 | Chip select, active low; high requests software power-down |
| wr_n | input | 1 | Write strobe; rising edge is a software trigger |
| rd_n | input | 1 | Read strobe; rising edge is a software trigger, low level after a conversion keeps the block awake |
| start_n | input | 1 | Hardware start pin; low phase is the sampling window |
| sw_mode | input | 1 | 1 = software start, 0 = hardware start |
| eoc_mode | input | 1 | 1 = busy-low level, 0 = one-clock interrupt pulse |
| int_clk_sel | input | 1 | 1 = local oscillator in use, gate it with `clk_en` |
| cmp | input | 1 | Comparator: 1 when the input is at or above `dac_code` |
| dac_code | output | 8 | Trial code for the external DAC |
| result | output | 8 | Latched conversion result |
| result_invalid | output | 1 | Marks the held result as the first after reset or software power-down |
| irq_n | output | 1 | Completion line, pulse or level per `eoc_mode` |
| sampling | output | 1 | High during the sampling window |
| auto_pd | output | 1 | Light power-down after an unread conversion |
| soft_pd | output | 1 | Software power-down, including resume clocks |
| clk_en | output | 1 | Enable for the local oscillator gate |

## Verification
The assertions take the three mode inputs as steady from a trigger until the clock after the conversion ends. They also take the strobes and the start pin as already synchronous to `clk`. The bench changes modes only before a trigger, while the block sits idle, powered down or waiting for a read. It drives every strobe on the falling clock edge and models the comparator as the comparison of a fixed analog code with `dac_code`. Random conversions mix both start sources, both completion styles, both clock sources, hardware windows of 1 to 12 clocks and reads that arrive or not. Directed cases cover codes 0x00 and 0xFF, retriggers during sampling, and chip-select pulses shorter and longer than the minimum power-down time.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_SAMPLE  = 3'd1,
    ST_CONVERT = 3'd2,
    ST_DONE    = 3'd3,
    ST_READ    = 3'd4,
    ST_APD     = 3'd5,
    ST_SPD     = 3'd6,
    ST_RESUME  = 3'd7
  } seq_state_e;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/adcseq_edge.sv
module adcseq_edge #(
  parameter int          N       = 4,
  parameter logic [31:0] RISE_MASK = 32'hFFFF_FFFF
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl,
  output logic [N-1:0] edge_o
);

  logic [N-1:0] lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= '1;
    else        lvl_q <= lvl;
  end

  for (genvar b = 0; b < N; b++) begin : g_edge
    if (RISE_MASK[b]) begin : g_rise
      assign edge_o[b] = lvl[b] & ~lvl_q[b];
    end else begin : g_fall
      assign edge_o[b] = ~lvl[b] & lvl_q[b];
    end
  end

endmodule

// File: rtl/adcseq_sar.sv
module adcseq_sar #(
  parameter int DATA_W = 8,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              test_en,
  input  logic [IDX_W-1:0]  test_idx,
  input  logic              sar_clr,
  input  logic              latch,
  input  logic              cmp,
  input  logic              pd_seen,
  output logic [DATA_W-1:0] dac_code,
  output logic [DATA_W-1:0] result,
  output logic              result_invalid
);

  logic [DATA_W-1:0] sar_q, sar_n;
  logic [DATA_W-1:0] trial;
  logic [DATA_W-1:0] res_n;
  logic              inv_n;

  // trial code: held bits plus the bit under test
  for (genvar b = 0; b < DATA_W; b++) begin : g_trial
    assign trial[b] = sar_q[b] | (test_en && (test_idx == IDX_W'(DATA_W - 1 - b)));
  end

  assign dac_code = trial;

  always_comb begin
    sar_n = sar_q;
    if (sar_clr)             sar_n = '0;
    else if (test_en && cmp) sar_n = trial;
  end

  always_comb begin
    res_n = result;
    inv_n = result_invalid;
    if (latch) begin
      res_n = sar_q;
      inv_n = pd_seen;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sar_q          <= '0;
      result         <= '0;
      result_invalid <= 1'b0;
    end else begin
      sar_q          <= sar_n;
      result         <= res_n;
      result_invalid <= inv_n;
    end
  end

  // R4: each trial differs from the held code by exactly the bit under test
  a_r4_one_trial_bit: assert property (@(posedge clk) disable iff (!rst_n)
    test_en |-> ($countones(trial ^ sar_q) == 1));

  // R4: the result only moves at the latch strobe
  a_r4_result_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !latch |=> $stable(result));

endmodule

// File: rtl/adcseq_ctrl.sv
module adcseq_ctrl
  import adcseq_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int IDX_W       = 3,
  parameter int SAMPLE_CLKS = 6,
  parameter int CONV_CLKS   = 10,
  parameter int SPD_MIN     = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             rd_n,
  input  logic             sw_mode,
  input  logic             eoc_mode,
  input  logic             int_clk_sel,
  input  logic             sw_trig,
  input  logic             st_fall,
  input  logic             st_rise,
  output logic             test_en,
  output logic [IDX_W-1:0] test_idx,
  output logic             sar_clr,
  output logic             latch,
  output logic             pd_seen,
  output logic             irq_n,
  output logic             sampling,
  output logic             auto_pd,
  output logic             soft_pd,
  output logic             clk_en
);

  localparam int CNT_MAX = imax(imax(SAMPLE_CLKS, CONV_CLKS), SPD_MIN);
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] SAMP_LAST = CNT_W'(SAMPLE_CLKS - 1);
  localparam logic [CNT_W-1:0] CONV_LAST = CNT_W'(CONV_CLKS - 1);
  localparam logic [CNT_W-1:0] SPD_LAST  = CNT_W'(SPD_MIN - 1);
  localparam logic [CNT_W-1:0] LATCH_AT  = CNT_W'(DATA_W);

  seq_state_e       state, state_n;
  logic [CNT_W-1:0] cnt, cnt_n;
  logic             samp_sw, samp_sw_n;
  logic             pd_seen_n;
  logic             trig;

  always_comb begin
    state_n   = state;
    cnt_n     = cnt;
    samp_sw_n = samp_sw;
    trig      = sw_mode ? sw_trig : st_fall;
    unique case (state)
      ST_IDLE, ST_READ, ST_APD: begin
        if (cs_n) begin
          state_n = ST_SPD;
          cnt_n   = '0;
        end else if (trig) begin
          state_n   = ST_SAMPLE;
          cnt_n     = '0;
          samp_sw_n = sw_mode;
        end
      end
      ST_SAMPLE: begin
        if (samp_sw) begin
          if (cnt == SAMP_LAST) begin
            state_n = ST_CONVERT;
            cnt_n   = '0;
          end else begin
            cnt_n = cnt + CNT_W'(1);
          end
        end else if (st_rise) begin
          state_n = ST_CONVERT;
          cnt_n   = '0;
        end
      end
      ST_CONVERT: begin
        if (cnt == CONV_LAST) begin
          state_n = ST_DONE;
          cnt_n   = '0;
        end else begin
          cnt_n = cnt + CNT_W'(1);
        end
      end
      ST_DONE: begin
        if (cs_n)       state_n = ST_SPD;
        else if (!rd_n) state_n = ST_READ;
        else            state_n = ST_APD;
        cnt_n = '0;
      end
      ST_SPD: begin
        if (cnt >= SPD_LAST && !cs_n) begin
          state_n = ST_RESUME;
          cnt_n   = '0;
        end else if (cnt < SPD_LAST) begin
          cnt_n = cnt + CNT_W'(1);
        end
      end
      ST_RESUME: begin
        if (cnt == SPD_LAST) begin
          state_n = ST_IDLE;
          cnt_n   = '0;
        end else begin
          cnt_n = cnt + CNT_W'(1);
        end
      end
      default: begin
        state_n = ST_IDLE;
        cnt_n   = '0;
      end
    endcase
  end

  // datapath strobes
  assign test_en  = (state == ST_CONVERT) && (cnt < LATCH_AT);
  assign test_idx = cnt[IDX_W-1:0];
  assign latch    = (state == ST_CONVERT) && (cnt == LATCH_AT);
  assign sar_clr  = (state != ST_CONVERT) && (state_n == ST_CONVERT);

  always_comb begin
    pd_seen_n = pd_seen;
    if (state == ST_SPD) pd_seen_n = 1'b1;
    else if (latch)      pd_seen_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      samp_sw <= 1'b1;
      pd_seen <= 1'b1;
    end else begin
      state   <= state_n;
      cnt     <= cnt_n;
      samp_sw <= samp_sw_n;
      pd_seen <= pd_seen_n;
    end
  end

  // status decode
  assign sampling = (state == ST_SAMPLE);
  assign auto_pd  = (state == ST_APD);
  assign soft_pd  = (state == ST_SPD) || (state == ST_RESUME);
  assign irq_n    = eoc_mode ? (state != ST_CONVERT) : (state != ST_DONE);
  assign clk_en   = !int_clk_sel ||
                    (state == ST_SAMPLE) || (state == ST_CONVERT) || (state == ST_DONE);

  // R11: once started, a conversion runs its full length
  a_r11_convert_runs: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_CONVERT && cnt != CONV_LAST) |=> (state == ST_CONVERT));

  // R7: no read in the clock after conversion leads to light power-down
  a_r7_apd_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DONE && rd_n && !cs_n) |=> (state == ST_APD));

  // R8: software power-down lasts at least two clocks
  a_r8_spd_dwell: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SPD && $past(state) != ST_SPD) |=> (state == ST_SPD));

endmodule

// File: rtl/adcseq_top.sv
module adcseq_top #(
  parameter int DATA_W      = 8,
  parameter int SAMPLE_CLKS = 6,
  parameter int SPD_MIN     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              wr_n,
  input  logic              rd_n,
  input  logic              start_n,
  input  logic              sw_mode,
  input  logic              eoc_mode,
  input  logic              int_clk_sel,
  input  logic              cmp,
  output logic [DATA_W-1:0] dac_code,
  output logic [DATA_W-1:0] result,
  output logic              result_invalid,
  output logic              irq_n,
  output logic              sampling,
  output logic              auto_pd,
  output logic              soft_pd,
  output logic              clk_en
);

  localparam int CONV_CLKS = DATA_W + 2;
  localparam int IDX_W     = $clog2(DATA_W);
  localparam int N_EDGE    = 4;

  logic rst_m, rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m <= 1'b0;
      rst_s <= 1'b0;
    end else begin
      rst_m <= 1'b1;
      rst_s <= rst_m;
    end
  end

  // channel 0: wr rise, 1: rd rise, 2: start fall, 3: start rise
  logic [N_EDGE-1:0] edges;
  adcseq_edge #(.N(N_EDGE), .RISE_MASK(32'h0000_000B)) u_edge (
    .clk   (clk),
    .rst_n (rst_s),
    .lvl   ({start_n, start_n, rd_n, wr_n}),
    .edge_o(edges)
  );

  logic sw_trig, st_fall, st_rise;
  assign sw_trig = !cs_n && (edges[0] || edges[1]);
  assign st_fall = !cs_n && edges[2];
  assign st_rise = edges[3];

  logic             test_en, sar_clr, latch, pd_seen;
  logic [IDX_W-1:0] test_idx;

  adcseq_ctrl #(
    .DATA_W(DATA_W), .IDX_W(IDX_W), .SAMPLE_CLKS(SAMPLE_CLKS),
    .CONV_CLKS(CONV_CLKS), .SPD_MIN(SPD_MIN)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_s),
    .cs_n       (cs_n),
    .rd_n       (rd_n),
    .sw_mode    (sw_mode),
    .eoc_mode   (eoc_mode),
    .int_clk_sel(int_clk_sel),
    .sw_trig    (sw_trig),
    .st_fall    (st_fall),
    .st_rise    (st_rise),
    .test_en    (test_en),
    .test_idx   (test_idx),
    .sar_clr    (sar_clr),
    .latch      (latch),
    .pd_seen    (pd_seen),
    .irq_n      (irq_n),
    .sampling   (sampling),
    .auto_pd    (auto_pd),
    .soft_pd    (soft_pd),
    .clk_en     (clk_en)
  );

  adcseq_sar #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_sar (
    .clk           (clk),
    .rst_n         (rst_s),
    .test_en       (test_en),
    .test_idx      (test_idx),
    .sar_clr       (sar_clr),
    .latch         (latch),
    .cmp           (cmp),
    .pd_seen       (pd_seen),
    .dac_code      (dac_code),
    .result        (result),
    .result_invalid(result_invalid)
  );

  // R5: the interrupt pulse is a single clock wide
  a_r5_int_one_clock: assert property (@(posedge clk) disable iff (!rst_s)
    (!irq_n && !eoc_mode && $stable(eoc_mode)) |=> irq_n);

endmodule

// File: tb/adcseq_top_tb.sv
module adcseq_top_tb;

  logic       clk = 1'b0;
  logic       rst_n, cs_n, wr_n, rd_n, start_n;
  logic       sw_mode, eoc_mode, int_clk_sel, cmp;
  logic [7:0] dac_code, result, analog;
  logic       result_invalid, irq_n, sampling, auto_pd, soft_pd, clk_en;
  int         n_chk = 0, n_err = 0;
  bit         fin = 1'b0;

  always #2 clk = ~clk;

  assign cmp = (analog >= dac_code);

  adcseq_top u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n),
    .start_n(start_n), .sw_mode(sw_mode), .eoc_mode(eoc_mode),
    .int_clk_sel(int_clk_sel), .cmp(cmp), .dac_code(dac_code),
    .result(result), .result_invalid(result_invalid), .irq_n(irq_n),
    .sampling(sampling), .auto_pd(auto_pd), .soft_pd(soft_pd), .clk_en(clk_en)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_samp(input bit sw, input int wid);
    return sw ? 6 : wid;
  endfunction

  function automatic int exp_gate(input bit iclk, input int ns);
    return iclk ? ns + 11 : 45;
  endfunction

  function automatic int exp_spd(input int h);
    return ((h > 2) ? h : 2) + 2;
  endfunction

  task automatic run_conv(input bit sw, input bit eoc, input bit iclk, input int wid,
                          input logic [7:0] v, input bit rd_it, input bit inv_exp,
                          input bit poke);
    int n_s, n_low, n_g, di;
    bit saw_low;
    n_s = 0; n_low = 0; n_g = 0; di = -1; saw_low = 1'b0;
    @(negedge clk);
    sw_mode = sw; eoc_mode = eoc; int_clk_sel = iclk; analog = v;
    if (sw) begin
      if (rd_n == 1'b0) rd_n = 1'b1;
      else begin
        wr_n = 1'b0;
        @(negedge clk);
        wr_n = 1'b1;
      end
    end else begin
      if (rd_n == 1'b0) begin
        rd_n = 1'b1;
        @(negedge clk);
      end
      start_n = 1'b0;
    end
    for (int i = 1; i <= 45; i++) begin
      @(negedge clk);
      if (!sw && i == wid) start_n = 1'b1;
      if (poke && i == 3) wr_n = 1'b0;
      if (poke && i == 4) wr_n = 1'b1;
      n_s += int'(sampling);
      n_g += int'(clk_en);
      if (!irq_n) begin
        n_low++;
        saw_low = 1'b1;
      end
      if (di < 0 && (eoc ? (saw_low && irq_n) : !irq_n)) begin
        di = i;
        chk(result == v, "R4 result", result, v);
        chk(result_invalid == inv_exp, "R9 invalid flag", result_invalid, inv_exp);
        if (rd_it) rd_n = 1'b0;
      end else if (di > 0 && i == di + 1) begin
        chk(auto_pd == !rd_it, "R7 auto power-down entry", auto_pd, !rd_it);
      end
    end
    chk(di > 0, "R5/R6 completion seen", di, 1);
    chk(n_s == exp_samp(sw, wid), sw ? "R2 sample clocks" : "R3 sample clocks",
        n_s, exp_samp(sw, wid));
    if (poke) chk(n_s == 6, "R11 retrigger ignored", n_s, 6);
    if (eoc) chk(n_low == 10, "R6 level low clocks", n_low, 10);
    else     chk(n_low == 1, "R5 pulse clocks", n_low, 1);
    chk(n_g == exp_gate(iclk, exp_samp(sw, wid)), "R10 gate clocks",
        n_g, exp_gate(iclk, exp_samp(sw, wid)));
    if (!rd_it) chk(auto_pd == 1'b1, "R7 auto power-down held", auto_pd, 1);
    else        chk(auto_pd == 1'b0, "R7 no power-down after read", auto_pd, 0);
  endtask

  task automatic spd_test(input int h);
    int n;
    n = 0;
    @(negedge clk);
    cs_n = 1'b1;
    for (int i = 1; i <= 14; i++) begin
      @(negedge clk);
      if (i == h) cs_n = 1'b0;
      n += int'(soft_pd);
    end
    chk(n == exp_spd(h), "R8 software power-down clocks", n, exp_spd(h));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!fin) begin
      n_err++;
      $display("FAIL watchdog (all requirements): actual timeout expected finish");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'h5EED_0A0C);
    rst_n = 1'b0; cs_n = 1'b0; wr_n = 1'b1; rd_n = 1'b1; start_n = 1'b1;
    sw_mode = 1'b1; eoc_mode = 1'b0; int_clk_sel = 1'b0; analog = 8'h00;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk(irq_n == 1'b1, "R1 irq_n", irq_n, 1);
    chk(sampling == 1'b0, "R1 sampling", sampling, 0);
    chk(auto_pd == 1'b0, "R1 auto_pd", auto_pd, 0);
    chk(soft_pd == 1'b0, "R1 soft_pd", soft_pd, 0);
    chk(result == 8'h00, "R1 result", result, 0);
    chk(result_invalid == 1'b0, "R1 result_invalid", result_invalid, 0);
    chk(clk_en == 1'b1, "R1 clk_en external", clk_en, 1);
    int_clk_sel = 1'b1;
    @(negedge clk);
    chk(clk_en == 1'b0, "R1 R10 clk_en internal idle", clk_en, 0);

    // directed cases
    run_conv(1, 0, 0, 0, 8'h5A, 1, 1, 0);
    run_conv(1, 1, 0, 0, 8'hFF, 0, 0, 0);
    run_conv(1, 0, 1, 0, 8'h00, 1, 0, 0);
    run_conv(1, 1, 1, 0, 8'h81, 1, 0, 1);
    run_conv(0, 1, 1, 1, 8'h3C, 0, 0, 0);
    run_conv(0, 0, 0, 12, 8'hC3, 1, 0, 0);
    spd_test(1);
    spd_test(5);
    run_conv(1, 0, 0, 0, 8'h7E, 1, 1, 0);
    run_conv(1, 0, 0, 0, 8'h01, 1, 0, 0);

    // random conversions
    for (int k = 0; k < 40; k++) begin
      bit sw_r, eoc_r, ic_r, rd_r, pk_r;
      int wid_r;
      logic [7:0] v_r;
      sw_r  = 1'($urandom_range(0, 1));
      eoc_r = 1'($urandom_range(0, 1));
      ic_r  = 1'($urandom_range(0, 1));
      rd_r  = 1'($urandom_range(0, 1));
      pk_r  = sw_r && ($urandom_range(0, 3) == 0);
      wid_r = int'($urandom_range(1, 12));
      v_r   = 8'($urandom_range(0, 255));
      run_conv(sw_r, eoc_r, ic_r, wid_r, v_r, rd_r, 0, pk_r);
    end

    fin = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule